// File: doc/BRIEF.md
# Trap Entry and Delegation Controller

This block performs the architectural trap-entry step of a privileged processor core. When the core raises a trap request (a cause number, an interrupt flag, the exception PC and a trap value), the controller picks the handling privilege level, machine (M) or supervisor (S). It then records cause, exception PC and trap value in that level's registers, pushes the status stack, derives the handler address from that level's trap-vector register and switches privilege. All of this happens in a single commit on the clock edge after the request.

Three special situations are folded into the same step. While the core is in debug mode, a trap only redirects the PC to one of two fixed debug addresses. A trap that would be delegated to S while the supervisor double-trap bit is already set is escalated to M with a dedicated double-trap cause. A machine-level trap that arrives while the machine double-trap bit is set, with detection enabled, raises a sticky critical-error flag and changes nothing else.

Software state is reached through a small register port: a one-cycle write port and a read port with one cycle of latency. The same port is used to set the current privilege, which stands in for the return path of the core.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset the PC output is RESET_PC, privilege is M (code 3, with U=0 and S=1), the critical-error flag is 0 and every register reads 0.
- R2: A register write takes effect on the next edge and a read returns data one cycle after the address is presented. The address map is: 0 privilege, 1 status, 2 environment config, 3 interrupt delegation, 4 exception delegation, 5 M vector, 6 M EPC, 7 M cause, 8 M tval, 9 M second tval, 10 S vector, 11 S EPC, 12 S cause, 13 S tval, and other addresses read 0. A privilege write of code 2 is stored as U. When an accepted trap and a write occur in the same cycle, the trap's update wins and the write is dropped.
- R3: In debug mode a trap changes no register and no privilege. A non-interrupt cause 3 sets the PC to DBG_ENTRY and any other trap sets it to DBG_TVEC.
- R4: A trap goes to S only when the current privilege is not M, the cause number is below XLEN, and the cause's bit is set in the interrupt delegation register (for interrupts) or in the exception delegation register (for exceptions). Otherwise it goes to M.
- R5: On S entry, S cause receives the interrupt flag in bit XLEN-1 and the cause number in the low bits, S EPC receives the exception PC and S tval receives the trap value. Privilege becomes S. In the status word, bit 2 (S previous enable) takes bit 0 (S enable), bit 4 takes privilege bit 0, and bit 0 is cleared.
- R6: On M entry, M cause, M EPC and M tval are written the same way and M second tval is written 0. Privilege becomes M. In the status word, bit 3 (M previous enable) takes bit 1 (M enable), bits 6:5 take the previous privilege, and bit 1 is cleared.
- R7: The new PC is the vector register with bit 0 cleared. When the vector's bit 0 is 1 and the trap is an interrupt, 4 times the cause number is added.
- R8: When a trap qualifies for S but status bit 7 (S double-trap) is already 1, it is taken in M instead. M cause is set to 16 and M second tval receives the original cause word, including the interrupt flag. No S register changes.
- R9: On S entry, status bit 7 is set only when environment-config bit 0 is 1. Otherwise it keeps its value.
- R10: With environment-config bit 1 set, an M entry sets status bit 8 (M double-trap). If bit 8 is already 1, the critical-error flag is raised instead and no register, PC or privilege changes. With environment-config bit 1 clear, bit 8 is left as it is.
- R11: The critical-error flag stays set until reset, and while it is set, trap requests are ignored.
- R12: The updates caused by a trap request, including PC and privilege, all become visible together on the clock edge that samples the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | One-cycle trap request strobe |
| trap_intr | input | 1 | Request is an interrupt |
| trap_cause | input | CAUSE_W | Cause number |
| trap_epc | input | XLEN | PC of the trapping instruction |
| trap_tval | input | XLEN | Trap value |
| dbg_mode | input | 1 | Core is in debug mode |
| csr_we | input | 1 | Register write enable |
| csr_waddr | input | 4 | Register write address |
| csr_wdata | input | XLEN | Register write data |
| csr_raddr | input | 4 | Register read address |
| csr_rdata | output | XLEN | Registered read data |
| pc_o | output | XLEN | Handler PC after the last trap |
| priv_o | output | 2 | Current privilege |
| crit_o | output | 1 | Sticky critical-error flag |

## Verification
The hardest states to reach are the two double-trap escalations. Each needs a prior trap, or a planted status bit, together with the right environment-config bit and a privilege below M, and all of these must line up before the trap that triggers it. The stimulus first arranges S entry with the supervisor double-trap enable set, so that the status bit is set by real trap entry. It then lowers the privilege through the register port and repeats the delegated trap. For the machine case, a first M trap sets the machine bit and a second one trips the critical flag. Further requests then show that the flag locks the PC.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int ADDR_W = 4;

  localparam logic [1:0] MODE_U = 2'd0;
  localparam logic [1:0] MODE_S = 2'd1;
  localparam logic [1:0] MODE_M = 2'd3;

  localparam logic [ADDR_W-1:0] A_MODE    = 4'd0;
  localparam logic [ADDR_W-1:0] A_STATUS  = 4'd1;
  localparam logic [ADDR_W-1:0] A_ENV     = 4'd2;
  localparam logic [ADDR_W-1:0] A_IDELEG  = 4'd3;
  localparam logic [ADDR_W-1:0] A_EDELEG  = 4'd4;
  localparam logic [ADDR_W-1:0] A_M_TVEC  = 4'd5;
  localparam logic [ADDR_W-1:0] A_M_EPC   = 4'd6;
  localparam logic [ADDR_W-1:0] A_M_CAUSE = 4'd7;
  localparam logic [ADDR_W-1:0] A_M_TVAL  = 4'd8;
  localparam logic [ADDR_W-1:0] A_M_TVAL2 = 4'd9;
  localparam logic [ADDR_W-1:0] A_S_TVEC  = 4'd10;
  localparam logic [ADDR_W-1:0] A_S_EPC   = 4'd11;
  localparam logic [ADDR_W-1:0] A_S_CAUSE = 4'd12;
  localparam logic [ADDR_W-1:0] A_S_TVAL  = 4'd13;

  localparam int STATUS_W = 9;
  localparam int ST_SIE  = 0;
  localparam int ST_MIE  = 1;
  localparam int ST_SPIE = 2;
  localparam int ST_MPIE = 3;
  localparam int ST_SPP  = 4;
  localparam int ST_MPP  = 5;
  localparam int ST_SDT  = 7;
  localparam int ST_MDT  = 8;

  localparam int ENV_W      = 2;
  localparam int ENV_S_DBL  = 0;
  localparam int ENV_M_DBL  = 1;

  localparam int CAUSE_BREAK  = 3;
  localparam int CAUSE_DOUBLE = 16;
endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic [1:0]         priv,
  input  logic               intr,
  input  logic [CAUSE_W-1:0] cause,
  input  logic [XLEN-1:0]    ideleg,
  input  logic [XLEN-1:0]    edeleg,
  input  logic               sdt,
  output logic               to_super,
  output logic               escalate
);
  localparam int IDX_W = $clog2(XLEN);

  logic             in_range;
  logic [IDX_W-1:0] idx;
  logic [XLEN-1:0]  sel_mask;
  logic             wants_s;

  generate
    if (CAUSE_W > IDX_W) begin : g_wide
      assign in_range = ~|cause[CAUSE_W-1:IDX_W];
    end else begin : g_narrow
      assign in_range = 1'b1;
    end
  endgenerate

  assign idx      = IDX_W'(cause);
  assign sel_mask = intr ? ideleg : edeleg;

  always_comb begin
    wants_s  = (priv != MODE_M) && in_range && sel_mask[idx];
    to_super = wants_s && !sdt;
    escalate = wants_s && sdt;
  end
endmodule

// File: rtl/trap_vec_calc.sv
module trap_vec_calc #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic [XLEN-1:0]    tvec,
  input  logic               intr,
  input  logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    target
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  always_comb begin
    base   = {tvec[XLEN-1:1], 1'b0};
    offset = (tvec[0] && intr) ? (XLEN'(cause) << 2) : '0;
    target = base + offset;
  end
endmodule

// File: rtl/trap_csr_bank.sv
module trap_csr_bank
  import trap_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = 32'h100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_waddr,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic [ADDR_W-1:0] csr_raddr,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic              go_dbg,
  input  logic              take_m,
  input  logic              take_s,
  input  logic              set_crit,
  input  logic [XLEN-1:0]   dbg_pc,
  input  logic [XLEN-1:0]   m_pc,
  input  logic [XLEN-1:0]   s_pc,
  input  logic [XLEN-1:0]   m_cause_val,
  input  logic [XLEN-1:0]   m_tval2_val,
  input  logic [XLEN-1:0]   s_cause_val,
  input  logic [XLEN-1:0]   epc,
  input  logic [XLEN-1:0]   tval,
  output logic [STATUS_W-1:0] status,
  output logic [ENV_W-1:0]  env,
  output logic [XLEN-1:0]   ideleg,
  output logic [XLEN-1:0]   edeleg,
  output logic [XLEN-1:0]   m_tvec,
  output logic [XLEN-1:0]   s_tvec,
  output logic [XLEN-1:0]   pc,
  output logic [1:0]        priv,
  output logic              crit
);
  logic [XLEN-1:0] m_epc, m_cause, m_tval, m_tval2;
  logic [XLEN-1:0] s_epc, s_cause, s_tval;
  logic [XLEN-1:0] rd_mux;
  logic            trap_busy;

  assign trap_busy = go_dbg || take_m || take_s || set_crit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= RESET_PC;
      priv    <= MODE_M;
      crit    <= 1'b0;
      status  <= '0;
      env     <= '0;
      ideleg  <= '0;
      edeleg  <= '0;
      m_tvec  <= '0;
      s_tvec  <= '0;
      m_epc   <= '0;
      m_cause <= '0;
      m_tval  <= '0;
      m_tval2 <= '0;
      s_epc   <= '0;
      s_cause <= '0;
      s_tval  <= '0;
    end else if (trap_busy) begin
      if (set_crit) begin
        crit <= 1'b1;
      end else if (go_dbg) begin
        pc <= dbg_pc;
      end else if (take_s) begin
        pc               <= s_pc;
        priv             <= MODE_S;
        s_cause          <= s_cause_val;
        s_epc            <= epc;
        s_tval           <= tval;
        status[ST_SPIE]  <= status[ST_SIE];
        status[ST_SPP]   <= priv[0];
        status[ST_SIE]   <= 1'b0;
        if (env[ENV_S_DBL]) status[ST_SDT] <= 1'b1;
      end else begin
        pc                         <= m_pc;
        priv                       <= MODE_M;
        m_cause                    <= m_cause_val;
        m_epc                      <= epc;
        m_tval                     <= tval;
        m_tval2                    <= m_tval2_val;
        status[ST_MPIE]            <= status[ST_MIE];
        status[ST_MPP+1:ST_MPP]    <= priv;
        status[ST_MIE]             <= 1'b0;
        if (env[ENV_M_DBL]) status[ST_MDT] <= 1'b1;
      end
    end else if (csr_we) begin
      case (csr_waddr)
        A_MODE:    priv    <= (csr_wdata[1:0] == 2'd2) ? MODE_U : csr_wdata[1:0];
        A_STATUS:  status  <= csr_wdata[STATUS_W-1:0];
        A_ENV:     env     <= csr_wdata[ENV_W-1:0];
        A_IDELEG:  ideleg  <= csr_wdata;
        A_EDELEG:  edeleg  <= csr_wdata;
        A_M_TVEC:  m_tvec  <= csr_wdata;
        A_M_EPC:   m_epc   <= csr_wdata;
        A_M_CAUSE: m_cause <= csr_wdata;
        A_M_TVAL:  m_tval  <= csr_wdata;
        A_M_TVAL2: m_tval2 <= csr_wdata;
        A_S_TVEC:  s_tvec  <= csr_wdata;
        A_S_EPC:   s_epc   <= csr_wdata;
        A_S_CAUSE: s_cause <= csr_wdata;
        A_S_TVAL:  s_tval  <= csr_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (csr_raddr)
      A_MODE:    rd_mux = XLEN'(priv);
      A_STATUS:  rd_mux = XLEN'(status);
      A_ENV:     rd_mux = XLEN'(env);
      A_IDELEG:  rd_mux = ideleg;
      A_EDELEG:  rd_mux = edeleg;
      A_M_TVEC:  rd_mux = m_tvec;
      A_M_EPC:   rd_mux = m_epc;
      A_M_CAUSE: rd_mux = m_cause;
      A_M_TVAL:  rd_mux = m_tval;
      A_M_TVAL2: rd_mux = m_tval2;
      A_S_TVEC:  rd_mux = s_tvec;
      A_S_EPC:   rd_mux = s_epc;
      A_S_CAUSE: rd_mux = s_cause;
      A_S_TVAL:  rd_mux = s_tval;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) csr_rdata <= '0;
    else     csr_rdata <= rd_mux;
  end

  AST_PRIV_LEGAL: assert property (@(posedge clk) disable iff (rst) priv != 2'd2); // R2
  AST_S_ENABLE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (take_s && !set_crit && !go_dbg) |=> !status[ST_SIE]); // R5
  AST_M_ENABLE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (take_m && !set_crit && !go_dbg && !take_s) |=> (!status[ST_MIE] && priv == MODE_M)); // R6
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              CAUSE_W   = 6,
  parameter logic [XLEN-1:0] RESET_PC  = 32'h0000_0100,
  parameter logic [XLEN-1:0] DBG_ENTRY = 32'h0000_0800,
  parameter logic [XLEN-1:0] DBG_TVEC  = 32'h0000_0808
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trap_valid,
  input  logic               trap_intr,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    trap_epc,
  input  logic [XLEN-1:0]    trap_tval,
  input  logic               dbg_mode,
  input  logic               csr_we,
  input  logic [3:0]         csr_waddr,
  input  logic [XLEN-1:0]    csr_wdata,
  input  logic [3:0]         csr_raddr,
  output logic [XLEN-1:0]    csr_rdata,
  output logic [XLEN-1:0]    pc_o,
  output logic [1:0]         priv_o,
  output logic               crit_o
);
  localparam int LEVELS = 2;   // index 0: machine, 1: supervisor

  logic [STATUS_W-1:0] status;
  logic [ENV_W-1:0]    env;
  logic [XLEN-1:0]     ideleg, edeleg, m_tvec, s_tvec;
  logic [XLEN-1:0]     vec_reg [LEVELS];
  logic [XLEN-1:0]     vec_tgt [LEVELS];

  logic accept, go_dbg, normal, to_super, escalate;
  logic m_path, crash, take_m, take_s;
  logic [XLEN-1:0] full_cause, m_cause_val, m_tval2_val, dbg_pc;

  trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_route (
    .priv     (priv_o),
    .intr     (trap_intr),
    .cause    (trap_cause),
    .ideleg   (ideleg),
    .edeleg   (edeleg),
    .sdt      (status[ST_SDT]),
    .to_super (to_super),
    .escalate (escalate)
  );

  assign vec_reg[0] = m_tvec;
  assign vec_reg[1] = s_tvec;

  generate
    for (genvar g = 0; g < LEVELS; g++) begin : g_vec
      trap_vec_calc #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vec (
        .tvec   (vec_reg[g]),
        .intr   (trap_intr),
        .cause  (trap_cause),
        .target (vec_tgt[g])
      );
    end
  endgenerate

  always_comb begin
    accept      = trap_valid && !crit_o;
    go_dbg      = accept && dbg_mode;
    normal      = accept && !dbg_mode;
    take_s      = normal && to_super;
    m_path      = normal && !to_super;
    crash       = m_path && env[ENV_M_DBL] && status[ST_MDT];
    take_m      = m_path && !crash;
    full_cause  = {trap_intr, {(XLEN-1-CAUSE_W){1'b0}}, trap_cause};
    m_cause_val = escalate ? XLEN'(CAUSE_DOUBLE) : full_cause;
    m_tval2_val = escalate ? full_cause : '0;
    dbg_pc      = (!trap_intr && trap_cause == CAUSE_W'(CAUSE_BREAK)) ? DBG_ENTRY : DBG_TVEC;
  end

  trap_csr_bank #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .csr_we      (csr_we),
    .csr_waddr   (csr_waddr),
    .csr_wdata   (csr_wdata),
    .csr_raddr   (csr_raddr),
    .csr_rdata   (csr_rdata),
    .go_dbg      (go_dbg),
    .take_m      (take_m),
    .take_s      (take_s),
    .set_crit    (crash),
    .dbg_pc      (dbg_pc),
    .m_pc        (vec_tgt[0]),
    .s_pc        (vec_tgt[1]),
    .m_cause_val (m_cause_val),
    .m_tval2_val (m_tval2_val),
    .s_cause_val (full_cause),
    .epc         (trap_epc),
    .tval        (trap_tval),
    .status      (status),
    .env         (env),
    .ideleg      (ideleg),
    .edeleg      (edeleg),
    .m_tvec      (m_tvec),
    .s_tvec      (s_tvec),
    .pc          (pc_o),
    .priv        (priv_o),
    .crit        (crit_o)
  );

  AST_CRIT_STICKY: assert property (@(posedge clk) disable iff (rst) crit_o |=> crit_o); // R11
  AST_CRIT_PC_FROZEN: assert property (@(posedge clk) disable iff (rst) crit_o |=> $stable(pc_o)); // R11
  AST_DBG_KEEPS_PRIV: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && dbg_mode && !crit_o) |=> $stable(priv_o)); // R3
  AST_DBG_PC_FIXED: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && dbg_mode && !crit_o) |=> (pc_o == DBG_ENTRY || pc_o == DBG_TVEC)); // R3
  AST_NO_DELEG_FROM_M: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && !dbg_mode && !crit_o && priv_o == MODE_M) |=> (priv_o == MODE_M)); // R4
endmodule

// File: tb/tb_trap_entry_ctrl.sv
`timescale 1ns/1ps
module tb_trap_entry_ctrl;
  localparam int XLEN = 32;
  localparam int CW   = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trap_valid = 0, trap_intr = 0, dbg_mode = 0, csr_we = 0;
  logic [CW-1:0]   trap_cause = '0;
  logic [XLEN-1:0] trap_epc = '0, trap_tval = '0, csr_wdata = '0;
  logic [3:0]      csr_waddr = '0, csr_raddr = '0;
  logic [XLEN-1:0] csr_rdata, pc_o;
  logic [1:0]      priv_o;
  logic            crit_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [XLEN-1:0] exp_q [$];
  string           tag_q [$];
  logic            rd_req = 0, rd_req_d = 0;

  always #4 clk = ~clk;

  trap_entry_ctrl dut (
    .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_intr(trap_intr),
    .trap_cause(trap_cause), .trap_epc(trap_epc), .trap_tval(trap_tval),
    .dbg_mode(dbg_mode), .csr_we(csr_we), .csr_waddr(csr_waddr),
    .csr_wdata(csr_wdata), .csr_raddr(csr_raddr), .csr_rdata(csr_rdata),
    .pc_o(pc_o), .priv_o(priv_o), .crit_o(crit_o)
  );

  always @(posedge clk) rd_req_d <= rd_req;

  // monitor: compares each registered read result against the scoreboard
  always @(negedge clk) begin
    if (rd_req_d && exp_q.size() > 0) begin
      logic [XLEN-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (csr_rdata !== e) begin
        failures++;
        $display("FAIL %s: actual=%h expected=%h", t, csr_rdata, e);
      end
    end
  end

  task automatic chk(input string t, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [XLEN-1:0] e, input string t);
    @(negedge clk);
    csr_raddr = a;
    rd_req = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [XLEN-1:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_waddr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic trap(input logic i, input int c, input logic [XLEN-1:0] e, input logic [XLEN-1:0] v);
    @(negedge clk);
    trap_valid = 1'b1; trap_intr = i; trap_cause = CW'(c); trap_epc = e; trap_tval = v;
    @(negedge clk);
    trap_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pc", pc_o, 32'h100);
    chk("R1 priv", XLEN'(priv_o), 32'd3);
    chk("R1 crit", XLEN'(crit_o), 32'd0);
    rd(4'd1, 32'h0, "R1 status");
    rd(4'd7, 32'h0, "R1 mcause");

    // R2 write/read, privilege legalisation
    wr(4'd5, 32'h2001);
    rd(4'd5, 32'h2001, "R2 mtvec readback");
    wr(4'd0, 32'd2);
    chk("R2 priv code2->U", XLEN'(priv_o), 32'd0);
    wr(4'd0, 32'd3);

    // R4/R6/R7: exception from M, everything delegated but M not delegable
    wr(4'd4, 32'hFFFF_FFFF);
    wr(4'd1, 32'h2);
    trap(1'b0, 2, 32'h40, 32'h55);
    chk("R7 pc exception no offset", pc_o, 32'h2000);
    chk("R4 stays M", XLEN'(priv_o), 32'd3);
    rd(4'd7, 32'd2, "R6 mcause");
    rd(4'd6, 32'h40, "R6 mepc");
    rd(4'd8, 32'h55, "R6 mtval");
    rd(4'd9, 32'h0, "R6 mtval2");
    rd(4'd1, 32'h68, "R6 status push");

    // R6/R7 vectored interrupt from U, not delegated
    wr(4'd1, 32'h0);
    wr(4'd3, 32'h0);
    wr(4'd0, 32'd0);
    trap(1'b1, 7, 32'h44, 32'h0);
    chk("R7 vectored pc", pc_o, 32'h201C);
    chk("R6 priv M", XLEN'(priv_o), 32'd3);
    rd(4'd7, 32'h8000_0007, "R6 interrupt cause");
    rd(4'd1, 32'h0, "R6 MPP from U");

    // R4/R5 delegated exception from U
    wr(4'd4, 32'h100);
    wr(4'd10, 32'h3001);
    wr(4'd1, 32'h1);
    wr(4'd0, 32'd0);
    trap(1'b0, 8, 32'h80, 32'h9);
    chk("R5 pc", pc_o, 32'h3000);
    chk("R5 priv S", XLEN'(priv_o), 32'd1);
    rd(4'd12, 32'd8, "R5 scause");
    rd(4'd11, 32'h80, "R5 sepc");
    rd(4'd13, 32'h9, "R5 stval");
    rd(4'd1, 32'h4, "R5 status push / R9 no SDT");
    rd(4'd7, 32'h8000_0007, "R5 mcause untouched");

    // R5/R7 delegated vectored interrupt from S
    wr(4'd3, 32'h20);
    wr(4'd1, 32'h1);
    trap(1'b1, 5, 32'h90, 32'h0);
    chk("R7 S vectored pc", pc_o, 32'h3014);
    rd(4'd12, 32'h8000_0005, "R5 s interrupt cause");
    rd(4'd1, 32'h14, "R5 SPP from S");

    // R4 cause beyond XLEN never delegates
    wr(4'd0, 32'd0);
    wr(4'd4, 32'hFFFF_FFFF);
    trap(1'b0, 40, 32'hB0, 32'h0);
    chk("R4 wide cause priv M", XLEN'(priv_o), 32'd3);
    rd(4'd7, 32'd40, "R4 wide cause mcause");

    // R9 S double-trap bit set when enabled
    wr(4'd2, 32'h1);
    wr(4'd0, 32'd0);
    wr(4'd4, 32'h100);
    wr(4'd1, 32'h0);
    trap(1'b0, 8, 32'h88, 32'h0);
    chk("R9 priv S", XLEN'(priv_o), 32'd1);
    rd(4'd1, 32'h80, "R9 SDT set");

    // R8 escalation
    wr(4'd0, 32'd0);
    trap(1'b0, 8, 32'hA0, 32'h7);
    chk("R8 priv M", XLEN'(priv_o), 32'd3);
    chk("R8 pc", pc_o, 32'h2000);
    rd(4'd7, 32'd16, "R8 double cause");
    rd(4'd9, 32'd8, "R8 mtval2 original");
    rd(4'd6, 32'hA0, "R8 mepc");
    rd(4'd11, 32'h88, "R8 sepc untouched");

    // R2 trap beats same-cycle write; R12 commit on the sampling edge
    @(negedge clk);
    trap_valid = 1'b1; trap_intr = 1'b0; trap_cause = CW'(1); trap_epc = 32'hE0; trap_tval = 32'h1234;
    csr_we = 1'b1; csr_waddr = 4'd8; csr_wdata = 32'hDEAD;
    chk("R12 pc before edge", pc_o, 32'h2000);
    @(negedge clk);
    trap_valid = 1'b0; csr_we = 1'b0;
    rd(4'd8, 32'h1234, "R2 trap wins over write");
    rd(4'd6, 32'hE0, "R12 epc committed");

    // R3 debug override
    dbg_mode = 1'b1;
    trap(1'b0, 3, 32'hF0, 32'h0);
    chk("R3 breakpoint entry", pc_o, 32'h800);
    chk("R3 priv kept", XLEN'(priv_o), 32'd3);
    trap(1'b1, 3, 32'hF4, 32'h0);
    chk("R3 interrupt 3 tvec", pc_o, 32'h808);
    wr(4'd0, 32'd0);
    wr(4'd4, 32'hFFFF_FFFF);
    trap(1'b0, 2, 32'hF8, 32'h0);
    chk("R3 other cause tvec", pc_o, 32'h808);
    chk("R3 priv U kept", XLEN'(priv_o), 32'd0);
    rd(4'd7, 32'd1, "R3 mcause untouched");
    rd(4'd12, 32'd8, "R3 scause untouched");
    dbg_mode = 1'b0;

    // R10 machine double trap
    wr(4'd0, 32'd3);
    wr(4'd2, 32'h0);
    wr(4'd1, 32'h100);
    trap(1'b0, 2, 32'hC0, 32'h0);
    chk("R10 no crit when disabled", XLEN'(crit_o), 32'd0);
    rd(4'd1, 32'h160, "R10 MDT kept");
    wr(4'd1, 32'h0);
    wr(4'd2, 32'h2);
    trap(1'b0, 2, 32'hC4, 32'h0);
    chk("R10 first entry no crit", XLEN'(crit_o), 32'd0);
    rd(4'd1, 32'h160, "R10 MDT set");
    trap(1'b0, 4, 32'hD0, 32'h0);
    chk("R10 crit raised", XLEN'(crit_o), 32'd1);
    chk("R10 pc frozen", pc_o, 32'h2000);
    rd(4'd6, 32'hC4, "R10 mepc untouched");
    rd(4'd7, 32'd2, "R10 mcause untouched");

    // R11 sticky and traps ignored
    dbg_mode = 1'b1;
    trap(1'b0, 3, 32'hD4, 32'h0);
    dbg_mode = 1'b0;
    chk("R11 pc ignored trap", pc_o, 32'h2000);
    chk("R11 crit sticky", XLEN'(crit_o), 32'd1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule